// File: doc/BRIEF.md
# Shared Hebbian Feature Extractor for Multi-Channel Spike Data

This block turns detected neural spikes into principal-component feature vectors with an incremental Hebbian learning rule. It is used by many recording channels. Every channel keeps its own set of weight vectors in a private bank. All channels share one arithmetic core, which takes the spike in segments of `SEG_L` samples per clock. There is no covariance storage. Each spike is projected onto the current weight vectors of its channel, and the projections are the features. The same spike then adjusts those weights in place.

A detector upstream presents a full spike vector, its channel number and a learning-rate shift, and pulses `start`. The core first sweeps the segments once and accumulates every projection. It then sweeps each weight vector in turn and writes back the updated segments. For every element it keeps a running residual `x - sum(y_k*w_k)`. When the last write is done, the core raises `done` for one cycle and presents the channel and the features. Only the bank of the channel that owns the core has its write enable open. Every other bank holds its contents.

Top module: `gha_share_core`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` and `done` are 0 until a start is accepted.
- R2: A `start` seen while idle is accepted at that clock edge. `busy` is then high for exactly (P_VEC+1)*(M_DIM/SEG_L)+2 cycles (42 at the defaults). `done` is high only in the last of those cycles. A `start` held during the `done` cycle is accepted on the next edge.
- R3: A `start` that arrives while `busy` is high is ignored. It causes no extra `done` and does not change the channel, the features or any weights.
- R4: Numbers are signed two's complement, 17 bits wide with 12 fraction bits. Spike element i sits at `spike_in[17i+16:17i]` and feature j at `feat_out[17j+16:17j]`. Feature j is sat((sum over i of w_j[i]*x[i]) >>> 12). Here sat clamps to [-65536, 65535] and >>> is an arithmetic shift.
- R5: For j = 0 to P_VEC-1 in order, and for each element i, with residual r initialised to x: e = sat(r - ((y_j*w_j[i]) >>> 12)), then w_j[i] = sat(w_j[i] + (((y_j*e) >>> 12) >>> s)), then r = e. The old w_j[i] is used in both products.
- R6: The learning-rate shift s is `eta_shift`, captured at acceptance. Changing it while busy has no effect on the running update.
- R7: A spike changes only the weights of its own channel. A channel that has not yet been trained responds with its reset weights.
- R8: During `done`, `chan_out` equals the channel given at acceptance.
- R9: A projection that exceeds the range is clamped to 65535 (or to -65536).
- R10: After reset, every channel holds w_j[i] = ((i+3j) mod 7 + 1) * 256, negated when bit j of i is 1. No weight is zero, so the first spike yields nonzero features.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the initial weights |
| start | input | 1 | Request to process the spike on the inputs |
| chan_in | input | $clog2(N_CH) | Channel owning the spike |
| spike_in | input | M_DIM*17 | Spike vector, element i at bits [17i+16:17i] |
| eta_shift | input | SHW | Learning-rate right shift |
| busy | output | 1 | Core is occupied by a spike |
| done | output | 1 | One-cycle pulse after write-back |
| chan_out | output | $clog2(N_CH) | Channel of the finished spike |
| feat_out | output | P_VEC*17 | Features, feature j at bits [17j+16:17j] |

## Verification
The bench aims at the idle/busy boundary. It holds `start` through the `done` cycle and expects acceptance one edge later. A core that re-armed a cycle early or late would shift every later comparison. It drives a competing start, with a different channel and vector, in the middle of a busy spell. A core that latched it would report the wrong channel or corrupt weights. It trains one channel repeatedly before using a fresh one. Missing write gating would then show as features that differ from the reset-weight projection. It also changes the shift mid-spell, which exposes a design that reads the shift live, and drives a spike strong enough to clamp a projection, which catches wrap-around arithmetic.

// File: rtl/gha_pkg.sv
package gha_pkg;
   parameter int DW   = 17;
   parameter int FRAC = 12;

   typedef logic signed [DW-1:0] word_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROJ,
      ST_NORM,
      ST_UPD,
      ST_FIN
   } core_st_t;

   localparam logic signed [63:0] WMAX = (64'sd1 <<< (DW-1)) - 64'sd1;
   localparam logic signed [63:0] WMIN = -(64'sd1 <<< (DW-1));

   // clamp a wide signed value into the word range
   function automatic word_t sat_w(input logic signed [63:0] v);
      logic signed [63:0] c;
      if (v > WMAX)      c = WMAX;
      else if (v < WMIN) c = WMIN;
      else               c = v;
      return c[DW-1:0];
   endfunction

   // reset pattern of weight vector j, element i (never zero)
   function automatic word_t init_w(input int j, input int i);
      int mag;
      mag = (((i + 3*j) % 7) + 1) << (FRAC-4);
      if (((i >> j) & 1) != 0) return word_t'(-mag);
      return word_t'(mag);
   endfunction
endpackage

// File: rtl/gha_wbank.sv
module gha_wbank
   import gha_pkg::*;
#(
   parameter int M_DIM = 64,
   parameter int P_VEC = 4,
   parameter int SEG_L = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic [((M_DIM/SEG_L)>1 ? $clog2(M_DIM/SEG_L) : 1)-1:0] rd_seg,
   output logic [P_VEC*SEG_L*DW-1:0]   rd_data,
   input  logic                        wr,
   input  logic [(P_VEC>1 ? $clog2(P_VEC) : 1)-1:0] wr_vec,
   input  logic [((M_DIM/SEG_L)>1 ? $clog2(M_DIM/SEG_L) : 1)-1:0] wr_seg,
   input  logic [SEG_L*DW-1:0]         wr_data
);
   localparam int NW = P_VEC * M_DIM;

   logic [NW*DW-1:0] mem_q;

   always_comb begin
      rd_data = '0;
      for (int j = 0; j < P_VEC; j++) begin
         for (int l = 0; l < SEG_L; l++) begin
            rd_data[(j*SEG_L + l)*DW +: DW] =
               mem_q[(j*M_DIM + int'(rd_seg)*SEG_L + l)*DW +: DW];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < P_VEC; j++) begin
            for (int i = 0; i < M_DIM; i++) begin
               mem_q[(j*M_DIM + i)*DW +: DW] <= init_w(j, i);
            end
         end
      end else if (en && wr) begin
         for (int l = 0; l < SEG_L; l++) begin
            mem_q[(int'(wr_vec)*M_DIM + int'(wr_seg)*SEG_L + l)*DW +: DW]
               <= wr_data[l*DW +: DW];
         end
      end
   end

   // R7: a bank without its enable keeps every weight
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(mem_q));
endmodule

// File: rtl/gha_sop.sv
module gha_sop
   import gha_pkg::*;
#(
   parameter int P_VEC = 4,
   parameter int SEG_L = 8,
   parameter int PSW   = 2*DW + 4
) (
   input  logic [P_VEC*SEG_L*DW-1:0] w_seg,
   input  logic [SEG_L*DW-1:0]       x_seg,
   output logic signed [PSW-1:0]     psum [P_VEC]
);
   for (genvar j = 0; j < P_VEC; j++) begin : g_dot
      always_comb begin
         logic signed [PSW-1:0]  s;
         logic signed [2*DW-1:0] pr;
         s = '0;
         for (int l = 0; l < SEG_L; l++) begin
            pr = $signed(w_seg[(j*SEG_L + l)*DW +: DW]) * $signed(x_seg[l*DW +: DW]);
            s  = s + PSW'(pr);
         end
         psum[j] = s;
      end
   end
endmodule

// File: rtl/gha_swu.sv
module gha_swu
   import gha_pkg::*;
#(
   parameter int SEG_L = 8,
   parameter int SHW   = 4
) (
   input  word_t              y,
   input  logic [SHW-1:0]     sh,
   input  logic [SEG_L*DW-1:0] w_seg,
   input  logic [SEG_L*DW-1:0] r_seg,
   output logic [SEG_L*DW-1:0] w_new,
   output logic [SEG_L*DW-1:0] r_new
);
   for (genvar l = 0; l < SEG_L; l++) begin : g_lane
      word_t                  w, r, e;
      logic signed [2*DW-1:0] p_yw, p_ye;
      logic signed [63:0]     g;

      assign w    = w_seg[l*DW +: DW];
      assign r    = r_seg[l*DW +: DW];
      assign p_yw = y * w;
      assign e    = sat_w(64'(r) - (64'(p_yw) >>> FRAC));
      assign p_ye = y * e;
      assign g    = (64'(p_ye) >>> FRAC) >>> sh;
      assign w_new[l*DW +: DW] = sat_w(64'(w) + g);
      assign r_new[l*DW +: DW] = e;
   end
endmodule

// File: rtl/gha_share_core.sv
module gha_share_core
   import gha_pkg::*;
#(
   parameter int N_CH  = 4,
   parameter int M_DIM = 64,
   parameter int P_VEC = 4,
   parameter int SEG_L = 8,
   parameter int SHW   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [$clog2(N_CH)-1:0]    chan_in,
   input  logic [M_DIM*DW-1:0]        spike_in,
   input  logic [SHW-1:0]             eta_shift,
   output logic                       busy,
   output logic                       done,
   output logic [$clog2(N_CH)-1:0]    chan_out,
   output logic [P_VEC*DW-1:0]        feat_out
);
   localparam int CHW  = $clog2(N_CH);
   localparam int SEGS = M_DIM / SEG_L;
   localparam int SEGW = (SEGS > 1) ? $clog2(SEGS) : 1;
   localparam int VW   = (P_VEC > 1) ? $clog2(P_VEC) : 1;
   localparam int PSW  = 2*DW + $clog2(SEG_L) + 1;
   localparam int AW   = 2*DW + $clog2(M_DIM) + 1;
   localparam int SW   = SEG_L * DW;

   if (M_DIM % SEG_L != 0) begin : g_chk_seg
      $error("SEG_L must divide M_DIM");
   end
   if (N_CH < 2) begin : g_chk_ch
      $error("N_CH must be at least 2");
   end
   if (FRAC < 4) begin : g_chk_frac
      $error("FRAC must be at least 4");
   end

   core_st_t               state_q;
   logic [CHW-1:0]         chan_q;
   logic [SHW-1:0]         sh_q;
   logic [SEGW-1:0]        seg_q;
   logic [VW-1:0]          vec_q;
   logic [M_DIM*DW-1:0]    r_q;
   logic signed [AW-1:0]   acc_q [P_VEC];
   word_t                  y_q   [P_VEC];

   logic [P_VEC*SW-1:0]    rd_all [N_CH];
   logic [P_VEC*SW-1:0]    rd_sel;
   logic [SW-1:0]          x_seg, w_seg, w_new, r_new;
   logic signed [PSW-1:0]  psum [P_VEC];
   logic                   wr_en;
   logic                   last_seg;

   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_FIN);
   assign chan_out = chan_q;
   assign wr_en    = (state_q == ST_UPD);
   assign last_seg = (seg_q == SEGW'(SEGS-1));

   for (genvar j = 0; j < P_VEC; j++) begin : g_feat
      assign feat_out[j*DW +: DW] = y_q[j];
   end

   // per-channel banks; only the owner of the core gets an enable
   for (genvar c = 0; c < N_CH; c++) begin : g_bank
      gha_wbank #(
         .M_DIM (M_DIM),
         .P_VEC (P_VEC),
         .SEG_L (SEG_L)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (busy && (chan_q == CHW'(c))),
         .rd_seg  (seg_q),
         .rd_data (rd_all[c]),
         .wr      (wr_en),
         .wr_vec  (vec_q),
         .wr_seg  (seg_q),
         .wr_data (w_new)
      );
   end

   assign rd_sel = rd_all[chan_q];
   assign x_seg  = r_q[int'(seg_q)*SW +: SW];
   assign w_seg  = rd_sel[int'(vec_q)*SW +: SW];

   gha_sop #(
      .P_VEC (P_VEC),
      .SEG_L (SEG_L),
      .PSW   (PSW)
   ) u_sop (
      .w_seg (rd_sel),
      .x_seg (x_seg),
      .psum  (psum)
   );

   gha_swu #(
      .SEG_L (SEG_L),
      .SHW   (SHW)
   ) u_swu (
      .y     (y_q[vec_q]),
      .sh    (sh_q),
      .w_seg (w_seg),
      .r_seg (x_seg),
      .w_new (w_new),
      .r_new (r_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         chan_q  <= '0;
         sh_q    <= '0;
         seg_q   <= '0;
         vec_q   <= '0;
         r_q     <= '0;
         for (int j = 0; j < P_VEC; j++) begin
            acc_q[j] <= '0;
            y_q[j]   <= '0;
         end
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  chan_q  <= chan_in;
                  sh_q    <= eta_shift;
                  r_q     <= spike_in;
                  seg_q   <= '0;
                  vec_q   <= '0;
                  for (int j = 0; j < P_VEC; j++) acc_q[j] <= '0;
                  state_q <= ST_PROJ;
               end
            end
            ST_PROJ: begin
               for (int j = 0; j < P_VEC; j++) acc_q[j] <= acc_q[j] + AW'(psum[j]);
               if (last_seg) begin
                  seg_q   <= '0;
                  state_q <= ST_NORM;
               end else begin
                  seg_q <= seg_q + SEGW'(1);
               end
            end
            ST_NORM: begin
               for (int j = 0; j < P_VEC; j++) y_q[j] <= sat_w(64'(acc_q[j]) >>> FRAC);
               state_q <= ST_UPD;
            end
            ST_UPD: begin
               r_q[int'(seg_q)*SW +: SW] <= r_new;
               if (last_seg) begin
                  seg_q <= '0;
                  if (vec_q == VW'(P_VEC-1)) state_q <= ST_FIN;
                  else                       vec_q   <= vec_q + VW'(1);
               end else begin
                  seg_q <= seg_q + SEGW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2: an idle start is taken at once
   a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R2: the done cycle is the final busy cycle
   a_r2_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R2: busy only rises from an accepted start
   a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R3: a running spike keeps its channel
   a_r3_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(chan_out));
endmodule

// File: tb/test_gha_share_core.sv
`timescale 1ns/1ps
module test_gha_share_core;
   localparam int N_CH  = 4;
   localparam int M_DIM = 64;
   localparam int P_VEC = 4;
   localparam int SEG_L = 8;
   localparam int SHW   = 4;
   localparam int DW    = 17;
   localparam int FRAC  = 12;
   localparam int LAT   = (P_VEC+1)*(M_DIM/SEG_L) + 2;
   localparam longint MAXV = 65535;
   localparam longint MINV = -65536;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [$clog2(N_CH)-1:0] chan_in = '0;
   logic [M_DIM*DW-1:0] spike_in = '0;
   logic [SHW-1:0] eta_shift = '0;
   logic busy, done;
   logic [$clog2(N_CH)-1:0] chan_out;
   logic [P_VEC*DW-1:0] feat_out;

   always #4 clk = ~clk;

   gha_share_core #(
      .N_CH(N_CH), .M_DIM(M_DIM), .P_VEC(P_VEC), .SEG_L(SEG_L), .SHW(SHW)
   ) i_gha_share_core (
      .clk(clk), .rst_n(rst_n), .start(start), .chan_in(chan_in),
      .spike_in(spike_in), .eta_shift(eta_shift), .busy(busy), .done(done),
      .chan_out(chan_out), .feat_out(feat_out)
   );

   int nchk = 0, nfail = 0, ncyc = 0;
   longint wm [N_CH][P_VEC][M_DIM];
   longint ey [P_VEC];
   longint last_feat [P_VEC];
   longint first_feat [P_VEC];
   int echan = 0, rem = 0, done_cnt = 0;
   bit drv_start = 0;
   int drv_chan = 0, drv_shift = 0;
   longint drv_x [M_DIM];
   string tag = "R4";

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
   endtask

   always @(posedge clk) begin
      ncyc++;
      if (ncyc > 100000) begin
         nfail++;
         $display("FAIL R2 watchdog cycles=%0d expected<%0d", ncyc, 100000);
         summary();
         $finish;
      end
   end

   task automatic chk(bit ok, string req, string what, longint got, longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
      end
   endtask

   function automatic longint sat(longint v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   function automatic longint w_init(int j, int i);
      longint m;
      m = longint'((((i + 3*j) % 7) + 1) * 256);
      return (((i >> j) & 1) != 0) ? -m : m;
   endfunction

   task automatic model_accept();
      longint r [M_DIM];
      longint acc, wy, e, g;
      for (int i = 0; i < M_DIM; i++) r[i] = drv_x[i];
      for (int j = 0; j < P_VEC; j++) begin
         acc = 0;
         for (int i = 0; i < M_DIM; i++) acc += wm[drv_chan][j][i] * r[i];
         ey[j] = sat(acc >>> FRAC);
      end
      for (int j = 0; j < P_VEC; j++) begin
         for (int i = 0; i < M_DIM; i++) begin
            wy = (ey[j] * wm[drv_chan][j][i]) >>> FRAC;
            e  = sat(r[i] - wy);
            g  = ((ey[j] * e) >>> FRAC) >>> drv_shift;
            wm[drv_chan][j][i] = sat(wm[drv_chan][j][i] + g);
            r[i] = e;
         end
      end
      echan = drv_chan;
   endtask

   task automatic tick();
      bit acc_now;
      start     = drv_start;
      chan_in   = drv_chan[$clog2(N_CH)-1:0];
      eta_shift = drv_shift[SHW-1:0];
      for (int i = 0; i < M_DIM; i++) spike_in[i*DW +: DW] = drv_x[i][DW-1:0];
      acc_now = drv_start && (rem == 0);
      @(posedge clk);
      @(negedge clk);
      if (acc_now) begin
         model_accept();
         rem = LAT;
      end else if (rem > 0) begin
         rem--;
      end
      chk(busy == (rem > 0), "R2", "busy", longint'(busy), longint'(rem > 0));
      chk(done == (rem == 1), "R2", "done", longint'(done), longint'(rem == 1));
      if (done) begin
         done_cnt++;
         chk(chan_out == echan, "R8", "chan_out", longint'(chan_out), longint'(echan));
         for (int j = 0; j < P_VEC; j++) begin
            last_feat[j] = longint'($signed(feat_out[j*DW +: DW]));
            chk(last_feat[j] == ey[j], tag, $sformatf("feature%0d", j), last_feat[j], ey[j]);
         end
      end
   endtask

   task automatic fill(int seed);
      int unsigned st;
      st = seed;
      for (int i = 0; i < M_DIM; i++) begin
         st = st * 1103515245 + 12345;
         drv_x[i] = longint'((st >> 12) % 8001) - 4000;
      end
   endtask

   task automatic run(int ch, int sh);
      drv_chan = ch; drv_shift = sh; drv_start = 1;
      tick();
      drv_start = 0;
      while (rem > 0) tick();
   endtask

   initial begin
      for (int c = 0; c < N_CH; c++)
         for (int j = 0; j < P_VEC; j++)
            for (int i = 0; i < M_DIM; i++) wm[c][j][i] = w_init(j, i);
      fill(1);

      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk(busy == 0, "R1", "busy in reset", longint'(busy), 0);
         chk(done == 0, "R1", "done in reset", longint'(done), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0, "R1", "idle after reset", longint'({busy, done}), 0);

      // R4 / R10: first spike against reset weights
      tag = "R4";
      fill(11);
      run(0, 3);
      for (int j = 0; j < P_VEC; j++) begin
         first_feat[j] = last_feat[j];
         chk(last_feat[j] != 0, "R10", $sformatf("nonzero feature%0d", j), last_feat[j], 1);
      end

      // R5: repeated training, several patterns and shifts
      tag = "R5";
      for (int k = 0; k < 4; k++) begin
         fill(100 + 7*k);
         run(0, 1 + k);
      end

      // R3: competing start in the middle of a busy spell
      tag = "R3";
      fill(23);
      drv_chan = 0; drv_shift = 2; drv_start = 1;
      tick();
      drv_start = 0;
      repeat (5) tick();
      done_cnt = 0;
      fill(999);
      drv_chan = 2; drv_start = 1;
      repeat (4) tick();
      drv_start = 0; drv_chan = 0;
      while (rem > 0) tick();
      chk(done_cnt == 1, "R3", "done pulses", longint'(done_cnt), 1);
      chk(chan_out == 0, "R3", "channel kept", longint'(chan_out), 0);

      // R2: start held through the done cycle is taken on the next edge
      tag = "R2";
      fill(31);
      drv_chan = 1; drv_shift = 4; drv_start = 1;
      tick();
      drv_start = 0;
      while (rem > 1) tick();
      fill(11);
      drv_chan = 1; drv_start = 1;
      tick();
      chk(rem == 0, "R2", "not taken in done cycle", longint'(rem), 0);
      tick();
      chk(busy == 1, "R2", "taken on next edge", longint'(busy), 1);
      drv_start = 0;
      while (rem > 0) tick();

      // R7: untouched channel 3 still shows the reset-weight projection
      tag = "R7";
      fill(11);
      run(3, 5);
      for (int j = 0; j < P_VEC; j++)
         chk(last_feat[j] == first_feat[j], "R7", $sformatf("fresh feature%0d", j),
             last_feat[j], first_feat[j]);

      // R6: shift changed mid-spell has no effect
      tag = "R6";
      fill(57);
      drv_chan = 3; drv_shift = 0; drv_start = 1;
      tick();
      drv_start = 0;
      tick();
      drv_shift = 15;
      while (rem > 0) tick();
      fill(57);
      run(3, 15);
      fill(58);
      run(3, 0);

      // R9: projection clamps at the top of the range
      tag = "R9";
      for (int i = 0; i < M_DIM; i++) drv_x[i] = ((i & 1) != 0) ? -60000 : 60000;
      run(2, 6);
      chk(last_feat[0] == MAXV, "R9", "clamped feature0", last_feat[0], MAXV);
      tag = "R5";
      fill(77);
      run(2, 2);

      summary();
      $finish;
   end
endmodule